// File: doc/BRIEF.md
# SD Card Clock Control Unit

This block holds the clock control register of an SD host controller and derives the SD card clock from the base clock it runs on. Software first sets the internal clock enable and polls the read-only stable flag. The flag comes up after a fixed settling count. Software then sets the card clock enable, and a divided clock appears on the card clock output. The divisor sits in the upper byte of the register. It holds half of the full division ratio, so the card clock runs at the base clock divided by twice the divisor.

The card clock is a registered divider output in the base clock domain. It can start only from its low level, and only while both the card clock enable and the stable flag are set. A high phase that has begun always runs to its full length, so the output never carries a runt pulse. A new divisor is picked up when the next low phase begins. The normal reprogramming sequence is to write zero to stop both clocks, enable the internal clock, wait for stable, then enable the card clock. The block also drives a one-cycle strobe toward the command and data paths in each base cycle whose closing edge raises the card clock.

Top module: `sdclk_ctrl`

## Requirements
- R1: After reset the register reads 0x0000, the card clock output is low and the clock-enable strobe is low.
- R2: The register layout is: divisor in bits [15:8], card clock enable in bit 2, stable flag in bit 1, internal clock enable in bit 0. Bits [7:3] always read 0. Bit 1 is read-only, and write data on it has no effect.
- R3: The stable flag reads 1 from the STABLE_CYCLES-th base clock edge after the edge that set internal clock enable. It reads 0 in the same cycle that internal clock enable reads 0.
- R4: The card clock can rise only while the card clock enable and the stable flag both read 1. Clearing either one while the output is high does not shorten the current high phase. After that phase the output stays low.
- R5: While the clock runs, each high phase and each low phase lasts D base clock cycles, where D is the divisor (card clock = base / 2D). A divisor of 0 behaves as 1.
- R6: A divisor written while the clock runs takes effect at the start of the next low phase. The low or high phase in progress, and a high phase that follows it, keep the old length.
- R7: Writing 0x0000 makes the register read 0x0000 (stable flag included) on the next cycle. The card clock then completes any high phase and stays low.
- R8: The clock-enable strobe is high exactly in those base cycles whose closing edge raises the card clock. It is never high while the card clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Register read data |
| card_clk_o | output | 1 | SD card clock |
| card_clk_en_o | output | 1 | Strobe in the base cycle before each card clock rise |

## Verification
Two events can land in the same base cycle: a register write that changes the divisor or clears an enable, and the divider reaching a phase boundary, most sharply the cycle in which it would raise the clock or begin a low phase. The bench provokes this in two ways. Directed writes are issued on the exact cycle a rise is observed. A long run of sparse random writes also lands on every phase offset. A behavioural model compares the register, the card clock and the strobe every cycle, so a write that cuts a high phase short, or a divisor that takes effect one phase early or late, shows up as a mismatch.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int unsigned DIV_LSB  = 8;
  localparam int unsigned SDEN_BIT = 2;
  localparam int unsigned STBL_BIT = 1;
  localparam int unsigned IEN_BIT  = 0;

  typedef struct packed {
    logic [7:0] div;
    logic       sd_en;
    logic       int_en;
  } ctl_t;
endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
  import sdclk_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  input  logic        stable_i,
  output ctl_t        ctl_o,
  output logic [15:0] rd_data_o
);
  ctl_t ctl_q;
  logic unused_wr;

  assign unused_wr = ^{wr_data_i[7:3], wr_data_i[STBL_BIT]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (wr_en_i) begin
      ctl_q.div    <= wr_data_i[DIV_LSB +: 8];
      ctl_q.sd_en  <= wr_data_i[SDEN_BIT];
      ctl_q.int_en <= wr_data_i[IEN_BIT];
    end
  end

  always_comb begin
    rd_data_o                = '0;
    rd_data_o[DIV_LSB +: 8]  = ctl_q.div;
    rd_data_o[SDEN_BIT]      = ctl_q.sd_en;
    rd_data_o[STBL_BIT]      = stable_i;
    rd_data_o[IEN_BIT]       = ctl_q.int_en;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/sdclk_stable.sv
module sdclk_stable #(
  parameter int unsigned STABLE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_en_i,
  output logic stable_o
);
  localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STABLE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!int_en_i)        cnt_q <= '0;
    else if (cnt_q != LIMIT)   cnt_q <= cnt_q + 1'b1;
  end

  // drop with the enable, not one cycle later
  assign stable_o = int_en_i && (cnt_q == LIMIT);
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             card_clk_o,
  output logic             rise_next_o
);
  logic [DIV_W-1:0] ph_q, act_q, half_new, cur;
  logic             clk_q, last;

  assign half_new = (div_i == '0) ? DIV_W'(1) : div_i;
  // fresh divisor sampled only on the first cycle of a low phase
  assign cur  = (!clk_q && ph_q == '0) ? half_new : act_q;
  assign last = (ph_q == cur - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q <= 1'b0;
      ph_q  <= '0;
      act_q <= DIV_W'(1);
    end else begin
      act_q <= cur;
      if (clk_q) begin
        if (last) begin
          clk_q <= 1'b0;
          ph_q  <= '0;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end else if (!run_i) begin
        ph_q <= '0;
      end else if (last) begin
        clk_q <= 1'b1;
        ph_q  <= '0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign card_clk_o  = clk_q;
  assign rise_next_o = !clk_q && run_i && last;
endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rd_data_o,
  output logic        card_clk_o,
  output logic        card_clk_en_o
);
  ctl_t ctl;
  logic stable;

  sdclk_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .stable_i  (stable),
    .ctl_o     (ctl),
    .rd_data_o (rd_data_o)
  );

  sdclk_stable #(.STABLE_CYCLES(STABLE_CYCLES)) u_stable (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .int_en_i (ctl.int_en),
    .stable_o (stable)
  );

  sdclk_div #(.DIV_W(8)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (ctl.sd_en && stable),
    .div_i       (ctl.div),
    .card_clk_o  (card_clk_o),
    .rise_next_o (card_clk_en_o)
  );
endmodule

// File: rtl/sdclk_ctrl_chk.sv
module sdclk_ctrl_chk #(
  parameter int unsigned STABLE_CYCLES = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] rd_data_o,
  input logic        card_clk_o,
  input logic        card_clk_en_o
);
  int unsigned ien_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ien_cnt <= 0;
    else if (!rd_data_o[0])          ien_cnt <= 0;
    else if (ien_cnt < STABLE_CYCLES) ien_cnt <= ien_cnt + 1;
  end

  AST_STABLE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[0] |-> !rd_data_o[1]); // R3
  AST_STABLE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[1] |-> ien_cnt >= STABLE_CYCLES); // R3
  AST_RISE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_clk_o) |-> $past(rd_data_o[2] && rd_data_o[1])); // R4
  AST_IEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[0] == $past(wr_data_i[0])); // R2
  AST_ZERO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i == 16'h0000) |=> rd_data_o == 16'h0000); // R7
  AST_EN_THEN_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_clk_en_o |=> card_clk_o); // R8
  AST_RISE_HAD_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_clk_o) |-> $past(card_clk_en_o)); // R8
  AST_EN_LOW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_clk_en_o |-> !card_clk_o); // R8
endmodule

bind sdclk_ctrl sdclk_ctrl_chk #(.STABLE_CYCLES(STABLE_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .rd_data_o     (rd_data_o),
  .card_clk_o    (card_clk_o),
  .card_clk_en_o (card_clk_en_o)
);

// File: tb/sdclk_ctrl_test.sv
module sdclk_ctrl_test;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        card_clk, card_en;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sdclk_ctrl #(.STABLE_CYCLES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .card_clk_o(card_clk), .card_clk_en_o(card_en)
  );

  // behavioural reference
  int m_div, m_sd, m_ie, m_scnt, m_clk, m_k, m_plen;
  int n_clk, n_k, n_plen, L;
  bit m_run;

  function automatic int hv(int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic bit m_stable();
    return (m_ie != 0) && (m_scnt == N);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_sd = 0; m_ie = 0; m_scnt = 0;
      m_clk = 0; m_k = 0; m_plen = 1;
    end else begin
      m_run = (m_sd != 0) && m_stable();
      n_clk = m_clk; n_k = m_k; n_plen = m_plen;
      if (m_clk != 0) begin
        if (m_k + 1 >= m_plen) begin n_clk = 0; n_k = 0; end
        else n_k = m_k + 1;
      end else if (!m_run) begin
        n_k = 0;
      end else begin
        L = (m_k == 0) ? hv(m_div) : m_plen;
        n_plen = L;
        if (m_k + 1 >= L) begin n_clk = 1; n_k = 0; end
        else n_k = m_k + 1;
      end
      m_clk = n_clk; m_k = n_k; m_plen = n_plen;
      if (m_ie == 0) m_scnt = 0;
      else if (m_scnt < N) m_scnt = m_scnt + 1;
      if (wr_en) begin
        m_div = int'(wr_data[15:8]);
        m_sd  = int'(wr_data[2]);
        m_ie  = int'(wr_data[0]);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    int exp_rd, exp_en;
    bit run;
    cyc++;
    if (rst_n && !done) begin
      run = (m_sd != 0) && m_stable();
      exp_rd = (m_div << 8) | (m_sd << 2) | (int'(m_stable()) << 1) | m_ie;
      exp_en = int'((m_clk == 0) && run &&
                    (m_k + 1 == ((m_k == 0) ? hv(m_div) : m_plen)));
      chk("R3 register readback", int'(rd_data), exp_rd);
      chk("R5 card clock level", int'(card_clk), m_clk);
      chk("R8 rise strobe", int'(card_en), exp_en);
    end
  end

  always @(negedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise();
    while (card_clk) @(negedge clk);
    while (!card_clk) @(negedge clk);
  endtask

  task automatic count_level(output int n, input int limit);
    logic v;
    v = card_clk; n = 0;
    while (card_clk == v && n < limit) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    step(3);
    chk("R1 reset read", int'(rd_data), 0);
    chk("R1 reset clock", int'(card_clk), 0);
    chk("R1 reset strobe", int'(card_en), 0);
    rst_n = 1'b1;
    step(2);

    // stable timing
    wr(16'h0301);
    step(N - 1);
    chk("R3 stable not yet", int'(rd_data[1]), 0);
    step(1);
    chk("R3 stable up", int'(rd_data[1]), 1);

    // read-only and reserved bits
    wr(16'h03FB);
    chk("R2 ro bits", int'(rd_data), 16'h0303);
    step(10);
    chk("R4 no run without sd_en", int'(card_clk), 0);

    // period
    wr(16'h0305);
    wait_rise();
    count_level(n, 100); chk("R5 high len div3", n, 3);
    count_level(n, 100); chk("R5 low len div3", n, 3);

    // divisor change during high phase
    wait_rise();
    wr(16'h0505);
    count_level(n, 100); chk("R6 old high kept", n + 1, 3);
    count_level(n, 100); chk("R6 new low len", n, 5);
    count_level(n, 100); chk("R6 new high len", n, 5);

    // disable at rise
    wr(16'h0405);
    step(12);
    wait_rise();
    wr(16'h0401);
    count_level(n, 100); chk("R4 high not cut", n + 1, 4);
    count_level(n, 30);  chk("R4 stays low", n, 30);

    // stop all
    wr(16'h0205);
    wait_rise();
    wr(16'h0000);
    chk("R7 zero read", int'(rd_data), 0);
    step(4);
    count_level(n, 20); chk("R7 stays low", n, 20);

    // divisor zero
    wr(16'h0001);
    step(N + 2);
    wr(16'h0005);
    wait_rise();
    count_level(n, 100); chk("R5 div0 high", n, 1);
    count_level(n, 100); chk("R5 div0 low", n, 1);

    // sparse random writes across phase offsets
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 16) == 0) begin
        logic [15:0] d;
        d[15:8] = 8'($urandom % 5);
        d[7:0]  = 8'($urandom);
        d[0]    = (($urandom % 8) != 0);
        wr(d);
      end else begin
        step(1);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule